// File: doc/BRIEF.md
# Edge/Level Interrupt Gateway

This block sits between a set of raw interrupt lines and the arbitration logic of an interrupt controller. Each line has its own gateway slot. A per-line mode bit picks what counts as an event: a rising edge, or the line being high. When a slot sees an event it raises its pending bit. The slot is then "in service". A claim pulse for that line clears the pending bit. Further events on the line are dropped until a complete pulse for that line arrives. Missed edges are not counted.

The arbiter reads the pending vector and issues claims. Software finishes its handler and issues completes. Claim and complete arrive as one-hot vectors, one bit per line. A level line that drops after it was latched stays pending, so the handler must check the peripheral itself. If a complete and a new event land in the same cycle, the event is remembered and accepted one cycle later.

Top module: `irq_gateway`

## Requirements
- R1: With mode bit 0 (level), a line that is high while its slot is idle is an event. Its pending bit is set after the next clock edge.
- R2: With mode bit 1 (edge), an event is a line that is high now and was low at the previous clock edge. The previous sample resets to 0. A line that stays high produces no further event.
- R3: A slot that is not in service accepts an event. Its pending bit and its in-service flag are both set at the next clock edge.
- R4: A claim bit for a pending source clears that pending bit at the next edge, whatever the line level. A claim bit for a source that is not pending has no effect.
- R5: From acceptance until a complete for that source, events on the line are ignored. Edges seen in that window are not remembered after completion.
- R6: A level line that falls after its pending bit was set does not clear the pending bit.
- R7: After a complete, a level line that is still high sets its pending bit again.
- R8: An event in the same cycle as the complete that ends service is accepted one cycle later. The pending bit then appears two edges after that cycle.
- R9: A complete for a source whose pending bit is still set is ignored. The slot stays in service after the later claim.
- R10: Synchronous active-high reset clears every pending bit, in-service flag, deferred event and edge sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | N_SRC | Raw interrupt lines |
| trig_edge_i | input | N_SRC | Per-line mode: 1 edge, 0 level |
| claim_i | input | N_SRC | One-hot claim pulse per line |
| done_i | input | N_SRC | One-hot complete pulse per line |
| pending_o | output | N_SRC | Pending bit per line |

## Verification
Two lines run in level mode and two in edge mode, side by side, so one stimulus step separates the two detection rules. Some patterns hold a line high across claim and complete; these show level re-arming against edge one-shot behaviour. Other patterns drop a line while it is pending, which shows that a latched level bit is held. Still others pulse new edges while the line is in service, which shows that missed edges are not counted. Further steps place an event on the same cycle as its complete, send a complete before the claim, send claims to idle lines, and assert reset with a line held high. Together these pin down the deferred acceptance, the ignored early complete and the reset clearing of the in-service flag.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic pend;
        logic busy;
        logic defer;
    } gw_state_t;

    localparam gw_state_t GW_IDLE = '{pend: 1'b0, busy: 1'b0, defer: 1'b0};

    function automatic logic gw_event(trig_mode_e mode, logic now, logic prev);
        return (mode == TRIG_EDGE) ? (now & ~prev) : now;
    endfunction

endpackage

// File: rtl/irq_gw_detect.sv
module irq_gw_detect
    import irq_gw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_i,
    input  trig_mode_e mode_i,
    output logic       evt_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= line_i;
    end

    always_comb evt_o = gw_event(mode_i, line_i, prev_q);

    // R2: a held-high edge-mode line fires once
    assert_edge_single_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_i == TRIG_EDGE && evt_o) |=> !(mode_i == TRIG_EDGE && evt_o));

endmodule

// File: rtl/irq_gw_slot.sv
module irq_gw_slot
    import irq_gw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pend_o
);

    gw_state_t st_q, st_d;
    logic      accept;
    logic      retire;

    always_comb begin
        accept = (evt_i | st_q.defer) & ~st_q.busy;
        retire = done_i & st_q.busy & ~st_q.pend;
        st_d   = st_q;
        if (accept) begin
            st_d.pend = 1'b1;
            st_d.busy = 1'b1;
        end else begin
            if (claim_i) st_d.pend = 1'b0;
            if (retire)  st_d.busy = 1'b0;
        end
        st_d.defer = evt_i & retire;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= GW_IDLE;
        else     st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R3: an event on an idle slot is latched at the next edge
    assert_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !st_q.busy) |=> st_q.pend);

    // R4: a claim of a pending source drops it
    assert_claim_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (claim_i && st_q.pend) |=> !st_q.pend);

    // R5: pending never stands without the in-service flag
    assert_pend_in_service_R5: assert property (@(posedge clk) disable iff (rst)
        st_q.pend |-> st_q.busy);

    // R6: an unclaimed pending bit holds whatever the line does
    assert_pend_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && !claim_i) |=> st_q.pend);

    // R9: service only ends on a complete while not pending
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && !(done_i && !st_q.pend)) |=> st_q.busy);

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
    import irq_gw_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] line_i,
    input  logic [N_SRC-1:0] trig_edge_i,
    input  logic [N_SRC-1:0] claim_i,
    input  logic [N_SRC-1:0] done_i,
    output logic [N_SRC-1:0] pending_o
);

    logic [N_SRC-1:0] evt;

    for (genvar g = 0; g < N_SRC; g++) begin : g_slot
        irq_gw_detect u_det (
            .clk    (clk),
            .rst    (rst),
            .line_i (line_i[g]),
            .mode_i (trig_mode_e'(trig_edge_i[g])),
            .evt_o  (evt[g])
        );

        irq_gw_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .evt_i   (evt[g]),
            .claim_i (claim_i[g]),
            .done_i  (done_i[g]),
            .pend_o  (pending_o[g])
        );
    end

    // R10: reset leaves nothing pending
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (pending_o == '0));

endmodule

// File: tb/irq_gateway_tb_top.sv
module irq_gateway_tb_top;

    localparam int N = 4;
    localparam logic [N-1:0] MODE = 4'b1010; // lines 1,3 edge; 0,2 level
    localparam int NV = 31;

    // {req, line, claim, done, expected pending after the edge}
    localparam logic [19:0] VEC [NV] = '{
        {4'd10, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R10 idle
        {4'd1,  4'b0011, 4'b0000, 4'b0000, 4'b0011}, // R1 level, R2 edge
        {4'd2,  4'b0001, 4'b0000, 4'b0000, 4'b0011}, // R2 edge line falls
        {4'd6,  4'b0000, 4'b0000, 4'b0000, 4'b0011}, // R6 level falls, held
        {4'd4,  4'b0000, 4'b0011, 4'b0000, 4'b0000}, // R4 claim
        {4'd5,  4'b0011, 4'b0000, 4'b0000, 4'b0000}, // R5 events while in service
        {4'd8,  4'b0001, 4'b0000, 4'b0011, 4'b0000}, // R8 complete with level high
        {4'd8,  4'b0001, 4'b0000, 4'b0000, 4'b0001}, // R8 deferred accepted; R5 edge lost
        {4'd2,  4'b0011, 4'b0000, 4'b0000, 4'b0011}, // R2 fresh edge
        {4'd4,  4'b0000, 4'b0011, 4'b0000, 4'b0000}, // R4 claim, lines low
        {4'd7,  4'b0000, 4'b0000, 4'b0011, 4'b0000}, // R7 complete, line low: no repend
        {4'd7,  4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R7 quiet
        {4'd2,  4'b1000, 4'b0000, 4'b0000, 4'b1000}, // R2 edge line 3
        {4'd4,  4'b0000, 4'b1000, 4'b0000, 4'b0000}, // R4 claim
        {4'd8,  4'b1000, 4'b0000, 4'b1000, 4'b0000}, // R8 edge with complete
        {4'd8,  4'b1000, 4'b0000, 4'b0000, 4'b1000}, // R8 edge accepted late
        {4'd4,  4'b0000, 4'b1000, 4'b0000, 4'b0000}, // R4
        {4'd5,  4'b0000, 4'b0000, 4'b1000, 4'b0000}, // R5 complete
        {4'd1,  4'b0100, 4'b0000, 4'b0000, 4'b0100}, // R1 level line 2
        {4'd9,  4'b0000, 4'b0000, 4'b0100, 4'b0100}, // R9 early complete
        {4'd6,  4'b0000, 4'b0000, 4'b0000, 4'b0100}, // R6 held
        {4'd4,  4'b0000, 4'b0100, 4'b0000, 4'b0000}, // R4 claim
        {4'd9,  4'b0100, 4'b0000, 4'b0000, 4'b0000}, // R9 still in service
        {4'd8,  4'b0100, 4'b0000, 4'b0100, 4'b0000}, // R8 complete with level high
        {4'd8,  4'b0000, 4'b0000, 4'b0000, 4'b0100}, // R8 deferred event
        {4'd4,  4'b0000, 4'b0100, 4'b0000, 4'b0000}, // R4
        {4'd5,  4'b0000, 4'b0000, 4'b0100, 4'b0000}, // R5 complete
        {4'd4,  4'b0000, 4'b1111, 4'b0000, 4'b0000}, // R4 claim on idle lines
        {4'd3,  4'b0001, 4'b0000, 4'b0000, 4'b0001}, // R3 idle slot accepts
        {4'd4,  4'b0001, 4'b0001, 4'b0000, 4'b0000}, // R4 claim with line high
        {4'd7,  4'b0001, 4'b0000, 4'b0001, 4'b0000}  // R7 complete, line high
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] line, claim, done, pend;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_gateway #(.N_SRC(N)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line),
        .trig_edge_i (MODE),
        .claim_i     (claim),
        .done_i      (done),
        .pending_o   (pend)
    );

    task automatic check(input int req, input logic [N-1:0] exp, input string what);
        checks++;
        if (pend !== exp) begin
            fails++;
            $display("FAIL R%0d %s: pending=%b expected=%b", req, what, pend, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] l, input logic [N-1:0] c,
                        input logic [N-1:0] d);
        @(negedge clk);
        line  = l;
        claim = c;
        done  = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        line = '0; claim = '0; done = '0;
        repeat (3) @(posedge clk);
        #1;
        check(10, 4'b0000, "reset state");
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][15:12], VEC[i][11:8], VEC[i][7:4]);
            check(int'(VEC[i][19:16]), VEC[i][3:0], $sformatf("vector %0d", i));
        end

        // R7: level line still high after complete pends again
        step(4'b0001, 4'b0000, 4'b0000);
        check(7, 4'b0001, "level re-pend after complete");

        // R10: reset with the line high clears and holds clear
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(10, 4'b0000, "reset clears pending");
        @(posedge clk);
        #1;
        check(10, 4'b0000, "reset holds with line high");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(10, 4'b0001, "in-service flag cleared by reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule